// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the addressing layer of a 1-Wire slave. It sits above a bit-level PHY that handles slot timing. The PHY hands the layer single-cycle strobes: a received bit, a request for a bit to transmit, and a bus reset that is flagged as long or short. After every reset the layer collects an 8-bit ROM command, least-significant bit first. It then runs that command against a 64-bit identity. The identity is built from a family code parameter, a serial number parameter, and a CRC-8 computed at elaboration.

Each command ends in one of two ways. Either the device is selected, and the `selected` output grants the bus to the memory-function layer above, or the layer goes idle and ignores the bus until the next reset. The layer also drives the overdrive speed flag for the PHY, and it keeps a resume flag so that a device matched earlier can be selected again with a short command.

Top module: `owc_rom_layer`

## Requirements
- R1: The identity is sent and compared least-significant bit first. Bits 7:0 hold the family code, bits 55:8 hold the serial number, and bits 63:56 hold the CRC-8 of bits 55:0. The CRC uses the polynomial x^8+x^5+x^4+1, is fed LSB first and starts from zero. Read ROM (33h) transmits these 64 bits on successive transmit requests and then selects the device.
- R2: `rst_n` low, or a `bus_reset` strobe, deselects the device and releases `tx_bit` to 1. A bus reset restarts command collection, while `rst_n` leaves the layer idle until the first bus reset.
- R3: Skip ROM (CCh) selects the device in the cycle after the eighth command bit.
- R4: Match ROM (55h) selects the device after it receives 64 bits that all equal the identity. The first bit that differs deselects the device, and every later bit is ignored until the next reset.
- R5: Search ROM (F0h) handles each identity bit in three steps. It transmits the bit, then transmits its complement, then reads the master's bit. A master bit that differs from the identity bit drops the device to idle with `tx_bit` released. Surviving all 64 rounds selects the device.
- R6: Overdrive Skip (3Ch) and Overdrive Match (69h) set `od_speed` in the cycle after the command byte. 3Ch then acts as Skip ROM and 69h acts as Match ROM.
- R7: A bus reset with `reset_long` high clears `od_speed`. A bus reset with `reset_long` low leaves it unchanged.
- R8: Resume (A5h) selects the device only when the resume flag is set, and otherwise goes idle. The flag is set by a successful Match or Overdrive Match. It is cleared by a failed match and by the decode of any command other than Resume.
- R9: An unrecognised command byte sends the layer idle. While the layer is idle or selected, `rx_valid` and `tx_req` have no effect, and `tx_bit` is 1 whenever the layer is not transmitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | One-cycle strobe: the PHY saw a reset pulse |
| reset_long | input | 1 | Qualifies `bus_reset`: the pulse exceeded the standard-speed minimum |
| rx_valid | input | 1 | One-cycle strobe: `rx_bit` holds a bit written by the master |
| rx_bit | input | 1 | Received bit value |
| tx_req | input | 1 | One-cycle strobe: the PHY consumes `tx_bit` in a read slot |
| tx_bit | output | 1 | Bit to send in the next read slot (1 means released) |
| od_speed | output | 1 | Overdrive speed flag for the PHY |
| selected | output | 1 | Device is addressed; the memory-function layer owns the bus |

## Verification
Match and Search are driven with the full identity and with a single wrong master bit at a randomly chosen position. This separates a comparison that stops at the first difference from one that checks only some bits or recovers later. Read ROM and Search are also run against the known CRC for the default identity, which shows whether the CRC-8 and the bit order are right. Sequences of Match, Skip and Resume with long and short resets then tell apart a resume flag that is wrongly set or wrongly cleared, and an overdrive flag that is cleared by the wrong kind of reset.

// File: rtl/owc_rom_pkg.sv
package owc_rom_pkg;

  localparam int FAM_W  = 8;
  localparam int SER_W  = 48;
  localparam int CRC_W  = 8;
  localparam int BODY_W = FAM_W + SER_W;
  localparam int ID_W   = BODY_W + CRC_W;
  localparam int CMD_W  = 8;

  localparam logic [7:0] OP_READ    = 8'h33;
  localparam logic [7:0] OP_MATCH   = 8'h55;
  localparam logic [7:0] OP_SEARCH  = 8'hF0;
  localparam logic [7:0] OP_SKIP    = 8'hCC;
  localparam logic [7:0] OP_RESUME  = 8'hA5;
  localparam logic [7:0] OP_OD_SKIP = 8'h3C;
  localparam logic [7:0] OP_OD_MAT  = 8'h69;

  typedef enum logic [2:0] {
    ST_CMD, ST_MATCH, ST_READ, ST_SRCH_ID, ST_SRCH_CMP, ST_SRCH_DIR, ST_SEL, ST_IDLE
  } rom_state_e;

  typedef enum logic [2:0] {
    ACT_READ, ACT_MATCH, ACT_SEARCH, ACT_SKIP, ACT_RESUME, ACT_NONE
  } rom_act_e;

  typedef struct packed {
    rom_act_e act;
    logic     od_set;
  } cmd_dec_t;

  // one serial CRC-8 step, taps of x^8+x^5+x^4+1 in reflected form
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic       fb;
    logic [7:0] n;
    fb   = c[0] ^ b;
    n    = {fb, c[7:1]};
    n[3] = n[3] ^ fb;
    n[2] = n[2] ^ fb;
    return n;
  endfunction

  function automatic logic [CRC_W-1:0] crc8_over(input logic [BODY_W-1:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < BODY_W; i++) c = crc8_step(c, d[i]);
    return c;
  endfunction

endpackage

// File: rtl/owc_id_store.sv
module owc_id_store
  import owc_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h02,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_0001_B81C,
  parameter int               IDX_W  = $clog2(ID_W)
) (
  input  logic [IDX_W-1:0] idx,
  output logic             id_bit
);
  localparam logic [BODY_W-1:0] BODY = {SERIAL, FAMILY};
  localparam logic [CRC_W-1:0]  CRC  = crc8_over(BODY);
  localparam logic [ID_W-1:0]   IDV  = {CRC, BODY};

  assign id_bit = IDV[idx];
endmodule

// File: rtl/owc_cmd_decode.sv
module owc_cmd_decode
  import owc_rom_pkg::*;
(
  input  logic [CMD_W-1:0] code,
  output cmd_dec_t         dec
);
  always_comb begin
    dec.od_set = 1'b0;
    unique case (code)
      OP_READ:    dec.act = ACT_READ;
      OP_MATCH:   dec.act = ACT_MATCH;
      OP_SEARCH:  dec.act = ACT_SEARCH;
      OP_SKIP:    dec.act = ACT_SKIP;
      OP_RESUME:  dec.act = ACT_RESUME;
      OP_OD_SKIP: begin dec.act = ACT_SKIP;  dec.od_set = 1'b1; end
      OP_OD_MAT:  begin dec.act = ACT_MATCH; dec.od_set = 1'b1; end
      default:    dec.act = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/owc_bit_counter.sv
module owc_bit_counter #(
  parameter int LIMIT = 64,
  parameter int CW    = $clog2(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (inc) value <= value + 1'b1;
  end
endmodule

// File: rtl/owc_rom_layer.sv
module owc_rom_layer
  import owc_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h02,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_0001_B81C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic reset_long,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_req,
  output logic tx_bit,
  output logic od_speed,
  output logic selected
);
  localparam int CW = $clog2(ID_W);
  localparam logic [CW-1:0] ID_LAST  = CW'(ID_W - 1);
  localparam logic [CW-1:0] CMD_LAST = CW'(CMD_W - 1);

  rom_state_e       state;
  logic [CW-1:0]    cnt;
  logic [CMD_W-2:0] sh;
  logic             resume_flag;
  logic             id_bit;
  cmd_dec_t         dec;

  // named events for the checker
  logic             cmd_done, bit_ok, match_miss, match_win, search_drop, tx_active, cnt_inc;
  logic [CMD_W-1:0] cmd_byte;

  assign cmd_byte    = {rx_bit, sh};
  assign cmd_done    = (state == ST_CMD) && rx_valid && (cnt == CMD_LAST);
  assign bit_ok      = (rx_bit == id_bit);
  assign match_miss  = (state == ST_MATCH) && rx_valid && !bit_ok;
  assign match_win   = (state == ST_MATCH) && rx_valid && bit_ok && (cnt == ID_LAST);
  assign search_drop = (state == ST_SRCH_DIR) && rx_valid && !bit_ok;
  assign tx_active   = (state == ST_READ) || (state == ST_SRCH_ID) || (state == ST_SRCH_CMP);

  assign cnt_inc = ((state == ST_CMD)      && rx_valid && !cmd_done) ||
                   ((state == ST_MATCH)    && rx_valid) ||
                   ((state == ST_READ)     && tx_req) ||
                   ((state == ST_SRCH_DIR) && rx_valid);

  owc_id_store #(.FAMILY(FAMILY), .SERIAL(SERIAL), .IDX_W(CW)) u_id (
    .idx(cnt), .id_bit(id_bit)
  );

  owc_cmd_decode u_dec (.code(cmd_byte), .dec(dec));

  owc_bit_counter #(.LIMIT(ID_W), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(bus_reset || cmd_done), .inc(cnt_inc), .value(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sh          <= '0;
      od_speed    <= 1'b0;
      resume_flag <= 1'b0;
    end else if (bus_reset) begin
      state <= ST_CMD;
      if (reset_long) od_speed <= 1'b0;
    end else begin
      unique case (state)
        ST_CMD: if (rx_valid) begin
          sh <= {rx_bit, sh[CMD_W-2:1]};
          if (cmd_done) begin
            if (dec.od_set) od_speed <= 1'b1;
            if (dec.act != ACT_RESUME) resume_flag <= 1'b0;
            unique case (dec.act)
              ACT_READ:   state <= ST_READ;
              ACT_MATCH:  state <= ST_MATCH;
              ACT_SEARCH: state <= ST_SRCH_ID;
              ACT_SKIP:   state <= ST_SEL;
              ACT_RESUME: state <= resume_flag ? ST_SEL : ST_IDLE;
              default:    state <= ST_IDLE;
            endcase
          end
        end
        ST_MATCH: if (rx_valid) begin
          if (!bit_ok) begin
            state       <= ST_IDLE;
            resume_flag <= 1'b0;
          end else if (cnt == ID_LAST) begin
            state       <= ST_SEL;
            resume_flag <= 1'b1;
          end
        end
        ST_READ:     if (tx_req && cnt == ID_LAST) state <= ST_SEL;
        ST_SRCH_ID:  if (tx_req) state <= ST_SRCH_CMP;
        ST_SRCH_CMP: if (tx_req) state <= ST_SRCH_DIR;
        ST_SRCH_DIR: if (rx_valid) begin
          if (!bit_ok)             state <= ST_IDLE;
          else if (cnt == ID_LAST) state <= ST_SEL;
          else                     state <= ST_SRCH_ID;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_READ, ST_SRCH_ID: tx_bit = id_bit;
      ST_SRCH_CMP:         tx_bit = ~id_bit;
      default:             tx_bit = 1'b1;
    endcase
  end

  assign selected = (state == ST_SEL);
endmodule

module owc_rom_layer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       reset_long,
  input logic       tx_bit,
  input logic       od_speed,
  input logic       selected,
  input logic       cmd_done,
  input logic [7:0] cmd_byte,
  input logic       match_miss,
  input logic       match_win,
  input logic       search_drop,
  input logic       tx_active,
  input logic       resume_flag
);
  // R2
  reset_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !selected);
  // R3
  skip_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !bus_reset && cmd_byte == 8'hCC) |=> selected);
  // R4
  match_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_miss && !bus_reset) |=> (!selected && !resume_flag));
  // R4
  match_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_win && !bus_reset) |=> (selected && resume_flag));
  // R5
  search_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_drop && !bus_reset) |=> (!selected && tx_bit));
  // R6
  od_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !bus_reset && (cmd_byte == 8'h3C || cmd_byte == 8'h69)) |=> od_speed);
  // R7
  od_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && reset_long) |=> !od_speed);
  // R7
  od_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !reset_long) |=> $stable(od_speed));
  // R8
  resume_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !bus_reset && cmd_byte == 8'hA5 && !resume_flag) |=> !selected);
  // R9
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> tx_bit);
endmodule

bind owc_rom_layer owc_rom_layer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
  .tx_bit(tx_bit), .od_speed(od_speed), .selected(selected),
  .cmd_done(cmd_done), .cmd_byte(cmd_byte), .match_miss(match_miss),
  .match_win(match_win), .search_drop(search_drop), .tx_active(tx_active),
  .resume_flag(resume_flag)
);

// File: tb/test_owc_rom_layer.sv
module test_owc_rom_layer;
  localparam logic [7:0]  FAM = 8'h02;
  localparam logic [47:0] SER = 48'h0000_0001_B81C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset = 1'b0, reset_long = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
  logic tx_bit, od_speed, selected;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] exp_id;

  always #4 clk = ~clk;

  owc_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) i_owc_rom_layer (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req),
    .tx_bit(tx_bit), .od_speed(od_speed), .selected(selected)
  );

  // bench CRC: reflected mask form
  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic f = c[0] ^ d[i];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); b = tx_bit; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic bus_rst(input logic lng);
    @(negedge clk); bus_reset = 1'b1; reset_long = lng;
    @(negedge clk); bus_reset = 1'b0; reset_long = 1'b0;
  endtask

  // send identity with an optional wrong bit at position bad (bad>=64: none)
  task automatic send_id(input int bad);
    for (int i = 0; i < 64; i++) send_bit(exp_id[i] ^ (i == bad));
  endtask

  // search; master's bit flipped at position bad; returns count of tx errors before drop
  task automatic do_search(input int bad, output int errs);
    logic a, b;
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      read_bit(a); read_bit(b);
      if (i <= bad || bad >= 64) begin
        if (a !== exp_id[i] || b !== ~exp_id[i]) errs++;
      end else if (a !== 1'b1 || b !== 1'b1) errs++;
      send_bit(exp_id[i] ^ (i == bad));
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] got;
    logic        b;
    int          e;
    exp_id = {ref_crc({SER, FAM}), SER, FAM};
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk(!selected && !od_speed && tx_bit, "R2 reset state", {selected, od_speed, tx_bit}, 3'b001);
    rst_n = 1'b1;
    // ignored before first bus reset
    send_byte(8'hCC);
    chk(!selected, "R9 idle before bus reset", selected, 0);

    // R1 read ROM, known CRC A2h
    bus_rst(1'b1);
    send_byte(8'h33);
    for (int i = 0; i < 64; i++) begin read_bit(b); got[i] = b; end
    chk(got === exp_id && exp_id[63:56] == 8'hA2, "R1 read rom identity", got, exp_id);
    chk(selected, "R1 selected after read", selected, 1);
    send_bit(1'b0); read_bit(b);
    chk(selected && b, "R9 selected ignores bits", {selected, b}, 2'b11);

    // R3 skip
    bus_rst(1'b0);
    chk(!selected, "R2 bus reset deselects", selected, 0);
    send_byte(8'hCC);
    chk(selected && !od_speed, "R3 skip selects", {selected, od_speed}, 2'b10);

    // R4 match, full and mismatch at ends
    bus_rst(1'b1); send_byte(8'h55); send_id(99);
    chk(selected, "R4 match full", selected, 1);
    bus_rst(1'b1); send_byte(8'h55); send_id(0);
    chk(!selected && tx_bit, "R4 match bit0 wrong", selected, 0);
    bus_rst(1'b1); send_byte(8'h55); send_id(63);
    chk(!selected, "R4 match bit63 wrong", selected, 0);

    // R8 resume after failed match is refused
    bus_rst(1'b1); send_byte(8'hA5);
    chk(!selected, "R8 resume refused after miss", selected, 0);
    bus_rst(1'b1); send_byte(8'h55); send_id(99);
    bus_rst(1'b1); send_byte(8'hA5);
    chk(selected, "R8 resume after match", selected, 1);
    bus_rst(1'b1); send_byte(8'hA5);
    chk(selected, "R8 resume repeatable", selected, 1);
    bus_rst(1'b1); send_byte(8'hCC);
    bus_rst(1'b1); send_byte(8'hA5);
    chk(!selected, "R8 skip clears resume", selected, 0);

    // R5 search win and drop
    bus_rst(1'b1); send_byte(8'hF0); do_search(99, e);
    chk(e == 0 && selected, "R5 search win", {e[7:0], selected}, 9'h001);
    bus_rst(1'b1); send_byte(8'hF0); do_search(10, e);
    chk(e == 0 && !selected && tx_bit, "R5 search drop at 10", {e[7:0], selected}, 9'h000);

    // R6 / R7 overdrive
    bus_rst(1'b1); send_byte(8'h3C);
    chk(od_speed && selected, "R6 od skip", {od_speed, selected}, 2'b11);
    bus_rst(1'b0);
    chk(od_speed, "R7 short reset keeps od", od_speed, 1);
    bus_rst(1'b1);
    chk(!od_speed, "R7 long reset clears od", od_speed, 0);
    send_byte(8'h69);
    chk(od_speed && !selected, "R6 od match flag at decode", {od_speed, selected}, 2'b10);
    send_id(99);
    chk(selected, "R6 od match selects", selected, 1);
    bus_rst(1'b0); send_byte(8'hA5);
    chk(selected && od_speed, "R8 resume after od match", {selected, od_speed}, 2'b11);

    // R9 unknown command
    bus_rst(1'b1); send_byte(8'h96);
    chk(!selected, "R9 unknown idle", selected, 0);
    send_byte(8'hCC); read_bit(b);
    chk(!selected && b, "R9 idle ignores bits", {selected, b}, 2'b01);

    // random trials
    for (int t = 0; t < 40; t++) begin
      int kind = $urandom_range(0, 2);
      int bad  = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 63) : 99;
      bus_rst(1'b1);
      if (kind == 0) begin
        send_byte(8'h55); send_id(bad);
        chk(selected == (bad >= 64), "R4 random match", selected, bad >= 64);
      end else if (kind == 1) begin
        send_byte(8'hF0); do_search(bad, e);
        chk(e == 0 && selected == (bad >= 64), "R5 random search", {e[7:0], selected}, {8'h0, bad >= 64});
      end else begin
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) begin read_bit(b); got[i] = b; end
        chk(got === exp_id, "R1 random read", got, exp_id);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule